// File: doc/BRIEF.md
# Bipolar Line Decoder with Coding-Violation Checks

This block turns a received ternary line, already split into a positive-mark bit and a negative-mark bit, back into a single NRZ data bit per decode clock. It works in one of four line codes, chosen by a two-bit mode input: plain alternate mark inversion, or one of three zero-substitution codes (eight-zero, six-zero and the four-zero high density code). Each received symbol is classified as it arrives: zero, single mark, double mark, or a mark that repeats the polarity of the previous mark. A short delay line holds the most recent symbols. When the newest symbols complete a valid substitution pattern, every bit of that pattern is turned to zero before it reaches the output.

Anything that breaks the selected code is flagged on an error output. This covers a repeated-polarity mark outside a valid pattern, both marks high together, and a zero run longer than the mode allows. The flag lines up with the bit it concerns. A loopback control replaces the external mark inputs with the local encoder's marks. A recovered-clock indication gives the OR of the two marks that are currently selected.

Top module: `bipolar_line_decoder`

## Requirements
- R1: The mark inputs are sampled on the rising clock edge. Exchanging the positive and negative inputs leaves nrz_out and err_out unchanged.
- R2: The mode encoding is 00 = AMI (window 1), 01 = B8ZS (window 8), 10 = B6ZS (window 6) and 11 = HDB3 (window 4). A symbol sampled at edge k appears on nrz_out after edge k+W-1, where W is the window of the current mode.
- R3: A valid substitution decodes to all zeros, with err_out low on every bit of it. The valid substitutions are 000VB0VB in B8ZS, 0VB0VB in B6ZS, and 000V or B00V in HDB3. V is a mark with the same polarity as the mark before it, and B is a mark of the opposite polarity. A single mark or zero that is not in a substitution decodes as 1 or 0.
- R4: A mark with the same polarity as the previous mark, and not part of a valid substitution, decodes as 1. err_out is high for that bit alone.
- R5: If both mark inputs are high in one bit, that bit decodes as 1 with err_out high. It does not change the polarity reference used for the next mark.
- R6: err_out is high on the zero that makes a run of consecutive line zeros exceed the mode's limit (AMI 15, B8ZS 8, B6ZS 6, HDB3 4), so the 16th, 9th, 7th or 5th zero. It is not high on the zeros before it.
- R7: With loop_en high, enc_pos and enc_neg drive the decoder and pos_in and neg_in have no effect.
- R8: rclk_out is the OR of the selected marks: pos_in|neg_in normally, enc_pos|enc_neg in loopback.
- R9: An active-low reset clears nrz_out and err_out to 0 and forgets the last polarity. The first mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Line code select (see R2) |
| loop_en | input | 1 | 1 = decode the encoder marks instead of the line |
| pos_in | input | 1 | Received positive-mark bit |
| neg_in | input | 1 | Received negative-mark bit |
| enc_pos | input | 1 | Local encoder positive mark (loopback source) |
| enc_neg | input | 1 | Local encoder negative mark (loopback source) |
| nrz_out | output | 1 | Decoded NRZ data |
| err_out | output | 1 | Coding-error flag aligned with nrz_out |
| rclk_out | output | 1 | OR of the selected marks |

## Verification
Two things can happen on the same edge. A substitution can complete in the newest symbol while its oldest bit is leaving the delay line, so the clear and the output register must act together. The same edge can also release a repeated-polarity mark that is not part of any pattern. Random streams from a bench-side encoder, which produce substitutions back to back and next to ordinary marks, provoke the first case. Directed near-miss patterns provoke the second: a wrong leading polarity in the eight-zero code, or too few zeros before a violation in the four-zero code. Each output bit is judged against the original data and the error flags the bench expects for it.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    LC_AMI  = 2'b00,
    LC_B8ZS = 2'b01,
    LC_B6ZS = 2'b10,
    LC_HDB3 = 2'b11
  } lc_mode_e;

  // one received symbol with its classification
  typedef struct packed {
    logic mk;    // exactly one mark high
    logic bth;   // both marks high
    logic viol;  // single mark repeating the previous polarity
    logic zx;    // zero that exceeds the allowed run
    logic sub;   // cleared as part of a valid substitution
  } lc_slot_t;

  localparam int LC_MAX_WIN = 8;

  function automatic int lc_win_len(input logic [1:0] m);
    case (m)
      LC_AMI:  return 1;
      LC_B8ZS: return 8;
      LC_B6ZS: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic int lc_zero_limit(input logic [1:0] m);
    case (m)
      LC_AMI:  return 15;
      LC_B8ZS: return 8;
      LC_B6ZS: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic logic lc_is_zero(input lc_slot_t s);
    return !s.mk && !s.bth;
  endfunction

  function automatic logic lc_mark_is(input lc_slot_t s, input logic v);
    return s.mk && (s.viol == v);
  endfunction

  function automatic logic lc_slot_data(input lc_slot_t s);
    return (s.mk || s.bth) && !s.sub;
  endfunction

  function automatic logic lc_slot_err(input lc_slot_t s);
    return s.bth || s.zx || (s.viol && !s.sub);
  endfunction

endpackage

// File: rtl/lc_input_sel.sv
module lc_input_sel (
  input  logic loop_en,
  input  logic pos_in,
  input  logic neg_in,
  input  logic enc_pos,
  input  logic enc_neg,
  output logic sel_pos,
  output logic sel_neg,
  output logic rclk
);
  always_comb begin
    sel_pos = loop_en ? enc_pos : pos_in;
    sel_neg = loop_en ? enc_neg : neg_in;
    rclk    = sel_pos | sel_neg;
  end
endmodule

// File: rtl/lc_classify.sv
module lc_classify
  import lc_pkg::*;
#(
  parameter int ZRUN_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sel_pos,
  input  logic       sel_neg,
  output lc_slot_t   slot_new
);
  localparam logic [ZRUN_W-1:0] RUN_MAX = {ZRUN_W{1'b1}};

  logic              last_neg;
  logic              seen_q;
  logic [ZRUN_W-1:0] run_q;
  logic              single, both, is_neg, is_zero;

  always_comb begin
    single  = sel_pos ^ sel_neg;
    both    = sel_pos & sel_neg;
    is_neg  = sel_neg & !sel_pos;
    is_zero = !sel_pos & !sel_neg;
    slot_new.mk   = single;
    slot_new.bth  = both;
    slot_new.viol = single && seen_q && (is_neg == last_neg);
    slot_new.zx   = is_zero && (run_q == ZRUN_W'(lc_zero_limit(mode)));
    slot_new.sub  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_neg <= 1'b0;
      seen_q   <= 1'b0;
      run_q    <= '0;
    end else begin
      if (single) begin
        last_neg <= is_neg;
        seen_q   <= 1'b1;
      end
      if (!is_zero)             run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/lc_match.sv
module lc_match
  import lc_pkg::*;
#(
  parameter int WIN = LC_MAX_WIN
) (
  input  logic [1:0] mode,
  input  lc_slot_t   win [WIN],
  output logic       hit,
  output logic [WIN-1:0] clr
);
  // index 0 is the newest symbol
  logic tail5, hit_b8, hit_b6, hit_hd;

  always_comb begin
    // V B 0 V B ending at the newest symbol, shared by both long codes
    tail5  = lc_mark_is(win[4], 1'b1) && lc_mark_is(win[3], 1'b0) &&
             lc_is_zero(win[2]) &&
             lc_mark_is(win[1], 1'b1) && lc_mark_is(win[0], 1'b0);
    hit_b6 = tail5 && lc_is_zero(win[5]);
    hit_b8 = hit_b6 && lc_is_zero(win[6]) && lc_is_zero(win[7]);
    hit_hd = !win[3].bth && !win[3].sub && !win[3].viol &&
             lc_is_zero(win[2]) && lc_is_zero(win[1]) &&
             lc_mark_is(win[0], 1'b1);
    case (mode)
      LC_B8ZS: hit = hit_b8;
      LC_B6ZS: hit = hit_b6;
      LC_HDB3: hit = hit_hd;
      default: hit = 1'b0;
    endcase
    for (int j = 0; j < WIN; j++)
      clr[j] = hit && (j < lc_win_len(mode));
  end
endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
  import lc_pkg::*;
#(
  parameter int ZRUN_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       loop_en,
  input  logic       pos_in,
  input  logic       neg_in,
  input  logic       enc_pos,
  input  logic       enc_neg,
  output logic       nrz_out,
  output logic       err_out,
  output logic       rclk_out
);
  localparam int WIN   = LC_MAX_WIN;
  localparam int TAP_W = $clog2(WIN);

  logic           sel_pos, sel_neg;
  lc_slot_t       slot_new;
  lc_slot_t       win_raw [WIN];
  lc_slot_t       win_clr [WIN];
  lc_slot_t       line_q  [WIN-1];
  logic [WIN-1:0] clr;
  logic           match_hit;
  logic [TAP_W-1:0] tap_idx;
  lc_slot_t       tap_slot;
  logic           tap_viol_live;

  lc_input_sel u_sel (
    .loop_en (loop_en), .pos_in (pos_in), .neg_in (neg_in),
    .enc_pos (enc_pos), .enc_neg (enc_neg),
    .sel_pos (sel_pos), .sel_neg (sel_neg), .rclk (rclk_out)
  );

  lc_classify #(.ZRUN_W(ZRUN_W)) u_cls (
    .clk (clk), .rst_n (rst_n), .mode (mode),
    .sel_pos (sel_pos), .sel_neg (sel_neg), .slot_new (slot_new)
  );

  assign win_raw[0] = slot_new;

  genvar g;
  generate
    for (g = 1; g < WIN; g++) begin : g_win
      assign win_raw[g] = line_q[g-1];
    end
    for (g = 0; g < WIN; g++) begin : g_clr
      always_comb begin
        win_clr[g]     = win_raw[g];
        win_clr[g].sub = win_raw[g].sub | clr[g];
      end
    end
    for (g = 0; g < WIN - 1; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q[g] <= '0;
        else        line_q[g] <= win_clr[g];
      end
    end
  endgenerate

  lc_match #(.WIN(WIN)) u_match (
    .mode (mode), .win (win_raw), .hit (match_hit), .clr (clr)
  );

  always_comb begin
    tap_idx       = TAP_W'(lc_win_len(mode) - 1);
    tap_slot      = win_clr[tap_idx];
    tap_viol_live = tap_slot.viol && !tap_slot.sub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrz_out <= 1'b0;
      err_out <= 1'b0;
    end else begin
      nrz_out <= lc_slot_data(tap_slot);
      err_out <= lc_slot_err(tap_slot);
    end
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       loop_en,
  input logic       pos_in,
  input logic       neg_in,
  input logic       enc_pos,
  input logic       enc_neg,
  input logic       nrz_out,
  input logic       err_out,
  input logic       match_hit,
  input logic       tap_viol_live
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!nrz_out && !err_out)); // R9

  AST_AMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !loop_en && pos_in && !neg_in) |=> nrz_out); // R2

  AST_SUB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> !nrz_out); // R3

  AST_VIOL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    tap_viol_live |=> (err_out && nrz_out)); // R4

  AST_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !loop_en && pos_in && neg_in) |=> (nrz_out && err_out)); // R5

  AST_LOOP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && loop_en && (enc_pos || enc_neg)) |=> nrz_out); // R7
endmodule

bind bipolar_line_decoder lc_checker u_chk (.*);

// File: tb/tb_bipolar_line_decoder.sv
module tb_bipolar_line_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       loop_en = 1'b0;
  logic       pos_in = 1'b0, neg_in = 1'b0, enc_pos = 1'b0, enc_neg = 1'b0;
  logic       nrz_out, err_out, rclk_out;

  bipolar_line_decoder dut (
    .clk (clk), .rst_n (rst_n), .mode (mode), .loop_en (loop_en),
    .pos_in (pos_in), .neg_in (neg_in), .enc_pos (enc_pos), .enc_neg (enc_neg),
    .nrz_out (nrz_out), .err_out (err_out), .rclk_out (rclk_out)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic sp [512], sn [512], ed [512], ee [512], dat [512];
  int n = 0;

  function automatic int lat(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 8 : (m == 2'd2) ? 6 : 4;
  endfunction

  function automatic int sublen(input logic [1:0] m);
    return (m == 2'd0) ? 0 : lat(m);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // c: 0 zero, 1 positive, 2 negative, 3 both
  task automatic sym(input int idx, input int c, input logic d, input logic e);
    sp[idx] = (c == 1) || (c == 3);
    sn[idx] = (c == 2) || (c == 3);
    ed[idx] = d;
    ee[idx] = e;
  endtask

  task automatic blank(input int len);
    n = len;
    for (int i = 0; i < len; i++) sym(i, 0, 1'b0, 1'b0);
  endtask

  task automatic mk(input int idx, input bit ng);
    sp[idx] = !ng; sn[idx] = ng;
  endtask

  // bench-side encoder for random data
  task automatic encode(input logic [1:0] m);
    bit lneg = 1'b1;
    int cnt = 0;
    int i = 0;
    int zl = sublen(m);
    for (int k = 0; k < n; k++) begin
      sp[k] = 0; sn[k] = 0; ed[k] = dat[k]; ee[k] = 0;
    end
    while (i < n) begin
      bit allz = (zl > 0) && (i + zl <= n);
      for (int k = 0; k < zl && allz; k++) if (dat[i+k]) allz = 0;
      if (allz) begin
        if (m == 2'd1) begin
          mk(i+3, lneg); mk(i+4, !lneg); mk(i+6, !lneg); mk(i+7, lneg);
        end else if (m == 2'd2) begin
          mk(i+1, lneg); mk(i+2, !lneg); mk(i+4, !lneg); mk(i+5, lneg);
        end else if (cnt % 2 == 1) begin
          mk(i+3, lneg);
        end else begin
          lneg = !lneg; mk(i, lneg); mk(i+3, lneg);
        end
        cnt = 0;
        i += zl;
      end else begin
        if (dat[i]) begin lneg = !lneg; mk(i, lneg); cnt++; end
        i++;
      end
    end
  endtask

  task automatic rand_data(input logic [1:0] m, input int len, input int pct);
    int zrun = 0;
    n = len;
    for (int i = 0; i < len; i++) begin
      logic b = (i == 0) ? 1'b1 : ($urandom_range(99) < pct);
      if (m == 2'd0 && zrun >= 14) b = 1'b1;
      zrun = b ? 0 : zrun + 1;
      dat[i] = b;
    end
    encode(m);
  endtask

  task automatic run_stream(input logic [1:0] m, input bit lp, input bit swap, input string req);
    int L = lat(m);
    rst_n = 0; mode = m; loop_en = lp;
    pos_in = 0; neg_in = 0; enc_pos = 0; enc_neg = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < n + L; i++) begin
      logic a, b;
      @(negedge clk);
      if (i == 0) begin
        chk("R9", "reset nrz", nrz_out, 1'b0);
        chk("R9", "reset err", err_out, 1'b0);
      end
      if (i >= L) begin
        chk(req, $sformatf("nrz bit %0d", i - L), nrz_out, ed[i-L]);
        chk(req, $sformatf("err bit %0d", i - L), err_out, ee[i-L]);
      end
      a = (i < n) ? sp[i] : 1'b0;
      b = (i < n) ? sn[i] : 1'b0;
      if (swap) begin logic t = a; a = b; b = t; end
      if (lp) begin
        enc_pos = a; enc_neg = b;
        pos_in = 1'($urandom); neg_in = 1'($urandom);
      end else begin
        pos_in = a; neg_in = b;
      end
      #1;
      chk("R8", "rclk", rclk_out, lp ? (enc_pos | enc_neg) : (pos_in | neg_in));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));

    // R2 R3: random streams per mode from the bench encoder
    for (int m = 0; m < 4; m++) begin
      rand_data(2'(m), 140, (m == 0) ? 50 : 35);
      run_stream(2'(m), 1'b0, 1'b0, (m == 0) ? "R2" : "R3");
    end

    // R1: swapped mark inputs
    rand_data(2'd1, 120, 35);
    run_stream(2'd1, 1'b0, 1'b1, "R1");
    rand_data(2'd3, 120, 35);
    run_stream(2'd3, 1'b0, 1'b1, "R1");

    // R7: loopback with garbage on the line pins
    rand_data(2'd3, 120, 35);
    run_stream(2'd3, 1'b1, 1'b0, "R7");
    rand_data(2'd0, 60, 50);
    run_stream(2'd0, 1'b1, 1'b0, "R7");

    // R4: repeated polarity in AMI, flagged for that bit only
    blank(3); sym(0, 1, 1, 0); sym(1, 1, 1, 1); sym(2, 2, 1, 0);
    run_stream(2'd0, 1'b0, 1'b0, "R4");

    // R5: both high, polarity reference kept
    blank(4); sym(0, 1, 1, 0); sym(1, 3, 1, 1); sym(2, 1, 1, 1); sym(3, 2, 1, 0);
    run_stream(2'd0, 1'b0, 1'b0, "R5");

    // R9: first mark after reset negative, not a violation
    blank(2); sym(0, 2, 1, 0); sym(1, 1, 1, 0);
    run_stream(2'd0, 1'b0, 1'b0, "R9");

    // R6: AMI 15 zeros fine, 16th flagged
    blank(34); sym(0, 1, 1, 0); sym(16, 2, 1, 0); sym(32, 0, 0, 1); sym(33, 1, 1, 0);
    run_stream(2'd0, 1'b0, 1'b0, "R6");

    // R6: HDB3 4 zeros fine, 5th flagged
    blank(12); sym(0, 1, 1, 0); sym(5, 2, 1, 0); sym(10, 0, 0, 1); sym(11, 1, 1, 0);
    run_stream(2'd3, 1'b0, 1'b0, "R6");

    // R6: B6ZS 6 zeros fine, 7th flagged
    blank(16); sym(0, 1, 1, 0); sym(7, 2, 1, 0); sym(14, 0, 0, 1); sym(15, 1, 1, 0);
    run_stream(2'd2, 1'b0, 1'b0, "R6");

    // R6: B8ZS 8 zeros fine, 9th flagged
    blank(20); sym(0, 1, 1, 0); sym(9, 2, 1, 0); sym(18, 0, 0, 1); sym(19, 1, 1, 0);
    run_stream(2'd1, 1'b0, 1'b0, "R6");

    // R4: B8ZS near-miss with wrong leading polarity
    blank(9); sym(0, 1, 1, 0); sym(4, 2, 1, 0); sym(5, 1, 1, 0);
    sym(7, 1, 1, 1); sym(8, 2, 1, 0);
    run_stream(2'd1, 1'b0, 1'b0, "R4");

    // R4: HDB3 violation after a single zero is not a substitution
    blank(4); sym(0, 1, 1, 0); sym(2, 1, 1, 1); sym(3, 2, 1, 0);
    run_stream(2'd3, 1'b0, 1'b0, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule